// File: doc/BRIEF.md
# ADC Sequencing Controller with Settling Timer

This block sits between a software-visible control register and a multiplexed analog-to-digital front end. It holds the amplifier gain code, the single-ended/differential selection and the selected input channel, and drives them to the analog side. Whenever one of these settings changes, a settling timer starts so that the amplifier can recover. A settling busy flag stays high while the timer counts.

When the timer expires in automatic mode, the block starts a conversion by itself. In manual mode it waits for a software start strobe, and it accepts that strobe only when neither settling nor a conversion is in progress. The converter is abstract: it receives a one-cycle start pulse and answers with a one-cycle done pulse. Two interrupt sources are available: the end of settling and the end of a conversion. Each source has its own enable and latches a sticky pending bit that software clears by writing 1. A self-clearing reset bit in the control register aborts everything in flight.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset `ctrl_rdata` reads 0. Only bits 10:5 of the control register store a value. Bits 31:11 and 4:0 always read 0, and writes to them have no effect.
- R2: A control write with bit 11 set raises `conv_abort` for that cycle. In the next cycle both busy flags and both pending bits are 0. Bit 11 never reads back as 1.
- R3: `gain_sel` follows control bits 7:6: 00 is x1, 01 is x2, 10 is x4 and 11 is x8.
- R4: `diff_mode` follows control bit 5: 0 selects single-ended input and 1 selects differential input.
- R5: The settling timer restarts only on a write that changes the gain code, bit 5 or the channel. `settle_busy` is then high for exactly SETTLE_CYCLES cycles. A write that changes none of these leaves `settle_busy` low.
- R6: With control bit 8 set, `conv_start` pulses once in the cycle in which settling ends, and `conv_busy` is high from the next cycle until `conv_done` arrives.
- R7: With control bit 8 clear, settling ends without a conversion. A `start_wr` strobe starts a conversion only when `settle_busy` and `conv_busy` are both low. Otherwise the strobe is ignored.
- R8: When settling ends and control bit 9 is set, `irq_pending[0]` sets. If bit 9 is clear, it stays 0.
- R9: When `conv_busy` falls on `conv_done` and control bit 10 is set, `irq_pending[1]` sets. If bit 10 is clear, it stays 0.
- R10: Pending bits are sticky. An `irq_ack_wr` with a 1 in bit 0 or bit 1 of `irq_ack_data` clears the matching pending bit. `irq` is high while any pending bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 32 | Control register write data |
| ctrl_rdata | output | 32 | Control register read value |
| chan_wr | input | 1 | Channel select write strobe |
| chan_wdata | input | CHAN_W | New channel number |
| start_wr | input | 1 | Manual conversion start strobe |
| irq_ack_wr | input | 1 | Interrupt acknowledge strobe |
| irq_ack_data | input | 2 | Write-1-to-clear mask (bit0 settling, bit1 conversion) |
| conv_done | input | 1 | Converter finished pulse |
| conv_start | output | 1 | One-cycle conversion start pulse |
| conv_abort | output | 1 | One-cycle abort pulse to the converter |
| gain_sel | output | 2 | Amplifier gain code |
| diff_mode | output | 1 | 1 for differential input |
| chan_sel | output | CHAN_W | Selected input channel |
| settle_busy | output | 1 | Settling timer running |
| conv_busy | output | 1 | Conversion in progress |
| irq_pending | output | 2 | Pending interrupts (bit0 settling, bit1 conversion) |
| irq | output | 1 | Interrupt request |

## Verification
The settling path is driven by a gain change, a mode change, a channel change and a write that changes nothing. These four cases separate a real restart from a spurious one, and the length of the busy window is counted cycle by cycle. Conversions are started both automatically and by the manual strobe. The manual strobe is also sent during settling and during a conversion, which separates accepted starts from ignored ones. The interrupt paths run with their enables set and with them clear. The abort write is issued while settling is running and pending bits are set, which shows that it clears every piece of state.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int unsigned REG_W   = 32;
    localparam int unsigned BIT_DIF = 5;
    localparam int unsigned BIT_GLO = 6;
    localparam int unsigned BIT_AUT = 8;
    localparam int unsigned BIT_IST = 9;
    localparam int unsigned BIT_ICV = 10;
    localparam int unsigned BIT_RST = 11;

    typedef struct packed {
        logic       irq_conv_en;
        logic       irq_settle_en;
        logic       auto_mode;
        logic [1:0] gain;
        logic       diff;
    } ctrl_t;
endpackage

// File: rtl/adc_ctrl_reg.sv
module adc_ctrl_reg
    import adc_seq_pkg::*;
#(
    parameter int unsigned CHAN_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              chan_wr,
    input  logic [CHAN_W-1:0] chan_wdata,
    output ctrl_t             ctrl,
    output logic [CHAN_W-1:0] chan,
    output logic              restart,
    output logic              abort
);
    typedef struct packed {
        ctrl_t             ctrl;
        logic [CHAN_W-1:0] chan;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        restart = 1'b0;
        abort   = 1'b0;
        if (reg_wr) begin
            st_d.ctrl.irq_conv_en   = reg_wdata[BIT_ICV];
            st_d.ctrl.irq_settle_en = reg_wdata[BIT_IST];
            st_d.ctrl.auto_mode     = reg_wdata[BIT_AUT];
            st_d.ctrl.gain          = reg_wdata[BIT_GLO +: 2];
            st_d.ctrl.diff          = reg_wdata[BIT_DIF];
            abort                   = reg_wdata[BIT_RST];
            if ((st_d.ctrl.gain != st_q.ctrl.gain) || (st_d.ctrl.diff != st_q.ctrl.diff))
                restart = 1'b1;
        end
        if (chan_wr && (chan_wdata != st_q.chan)) begin
            st_d.chan = chan_wdata;
            restart   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl = st_q.ctrl;
    assign chan = st_q.chan;
endmodule

// File: rtl/adc_settle_timer.sv
module adc_settle_timer #(
    parameter int unsigned SETTLE_CYCLES = 1600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic abort,
    output logic busy,
    output logic done
);
    localparam int unsigned CNT_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(SETTLE_CYCLES);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (abort)              cnt_d = '0;
        else if (restart)       cnt_d = LOAD;
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CNT_W'(1)) && !restart && !abort;
endmodule

// File: rtl/adc_conv_track.sv
module adc_conv_track (
    input  logic clk,
    input  logic rst_n,
    input  logic auto_mode,
    input  logic settle_busy,
    input  logic settle_done,
    input  logic start_wr,
    input  logic conv_done,
    input  logic abort,
    output logic conv_start,
    output logic busy,
    output logic conv_end
);
    logic busy_d, busy_q;
    logic auto_go, man_go;

    always_comb begin
        auto_go    = auto_mode && settle_done;
        man_go     = start_wr && !settle_busy;
        conv_start = !abort && !busy_q && (auto_go || man_go);
        conv_end   = !abort && busy_q && conv_done;
        busy_d     = busy_q;
        if (abort)           busy_d = 1'b0;
        else if (conv_start) busy_d = 1'b1;
        else if (conv_end)   busy_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) busy_q <= 1'b0;
        else        busy_q <= busy_d;
    end

    assign busy = busy_q;
endmodule

// File: rtl/adc_irq_latch.sv
module adc_irq_latch #(
    parameter int unsigned NSRC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set,
    input  logic            ack_wr,
    input  logic [NSRC-1:0] ack_data,
    input  logic            abort,
    output logic [NSRC-1:0] pending,
    output logic            irq
);
    logic [NSRC-1:0] pend_d, pend_q;

    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            pend_d[i] = pend_q[i];
            if (ack_wr && ack_data[i]) pend_d[i] = 1'b0;
            if (set[i])                pend_d[i] = 1'b1;
            if (abort)                 pend_d[i] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pending = pend_q;
    assign irq     = |pend_q;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int unsigned SETTLE_CYCLES = 1600,
    parameter int unsigned CHAN_W        = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       ctrl_rdata,
    input  logic              chan_wr,
    input  logic [CHAN_W-1:0] chan_wdata,
    input  logic              start_wr,
    input  logic              irq_ack_wr,
    input  logic [1:0]        irq_ack_data,
    input  logic              conv_done,
    output logic              conv_start,
    output logic              conv_abort,
    output logic [1:0]        gain_sel,
    output logic              diff_mode,
    output logic [CHAN_W-1:0] chan_sel,
    output logic              settle_busy,
    output logic              conv_busy,
    output logic [1:0]        irq_pending,
    output logic              irq
);
    ctrl_t ctrl;
    logic  restart, abort, settle_done, conv_end;
    logic [1:0] irq_set;

    adc_ctrl_reg #(.CHAN_W(CHAN_W)) u_reg (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .chan_wr(chan_wr), .chan_wdata(chan_wdata), .ctrl(ctrl), .chan(chan_sel),
        .restart(restart), .abort(abort)
    );

    adc_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
        .clk(clk), .rst_n(rst_n), .restart(restart), .abort(abort),
        .busy(settle_busy), .done(settle_done)
    );

    adc_conv_track u_conv (
        .clk(clk), .rst_n(rst_n), .auto_mode(ctrl.auto_mode),
        .settle_busy(settle_busy), .settle_done(settle_done), .start_wr(start_wr),
        .conv_done(conv_done), .abort(abort), .conv_start(conv_start),
        .busy(conv_busy), .conv_end(conv_end)
    );

    assign irq_set = {conv_end && ctrl.irq_conv_en, settle_done && ctrl.irq_settle_en};

    adc_irq_latch #(.NSRC(2)) u_irq (
        .clk(clk), .rst_n(rst_n), .set(irq_set), .ack_wr(irq_ack_wr),
        .ack_data(irq_ack_data), .abort(abort), .pending(irq_pending), .irq(irq)
    );

    always_comb begin
        ctrl_rdata                  = '0;
        ctrl_rdata[BIT_ICV]         = ctrl.irq_conv_en;
        ctrl_rdata[BIT_IST]         = ctrl.irq_settle_en;
        ctrl_rdata[BIT_AUT]         = ctrl.auto_mode;
        ctrl_rdata[BIT_GLO +: 2]    = ctrl.gain;
        ctrl_rdata[BIT_DIF]         = ctrl.diff;
    end

    assign gain_sel   = ctrl.gain;
    assign diff_mode  = ctrl.diff;
    assign conv_abort = abort;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [31:0] reg_wdata,
    input logic [31:0] ctrl_rdata,
    input logic        chan_wr,
    input logic        start_wr,
    input logic        irq_ack_wr,
    input logic [1:0]  irq_ack_data,
    input logic        conv_start,
    input logic [1:0]  gain_sel,
    input logic        settle_busy,
    input logic        conv_busy,
    input logic [1:0]  irq_pending
);
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rdata[31:11] == '0) && (ctrl_rdata[4:0] == '0)); // R1
    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[11]) |=> (!settle_busy && !conv_busy && irq_pending == 2'b00)); // R2
    AST_GAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> $stable(gain_sel)); // R3
    AST_SETTLE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(settle_busy) |-> $past(reg_wr || chan_wr)); // R5
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && !(reg_wr && reg_wdata[11])) |=> conv_busy); // R6
    AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr && conv_busy) |-> !conv_start); // R7
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pending[0] && !(irq_ack_wr && irq_ack_data[0]) && !(reg_wr && reg_wdata[11]))
        |=> irq_pending[0]); // R10
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk chk_i (.*);

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb_top;
    localparam int unsigned N  = 12;
    localparam int unsigned CW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 0, chan_wr = 0, start_wr = 0, irq_ack_wr = 0, conv_done = 0;
    logic [31:0] reg_wdata = '0;
    logic [CW-1:0] chan_wdata = '0;
    logic [1:0] irq_ack_data = '0;
    logic [31:0] ctrl_rdata;
    logic conv_start, conv_abort, diff_mode, settle_busy, conv_busy, irq;
    logic [1:0] gain_sel, irq_pending;
    logic [CW-1:0] chan_sel;

    int checks = 0, errors = 0, starts = 0, aborts = 0;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (conv_start) starts++;
        if (conv_abort) aborts++;
    end

    adc_seq_ctrl #(.SETTLE_CYCLES(N), .CHAN_W(CW)) dut_i (.*);

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [31:0] d);
        @(negedge clk); reg_wr = 1; reg_wdata = d;
        @(negedge clk); reg_wr = 0; reg_wdata = '0;
    endtask

    task automatic wr_chan(input logic [CW-1:0] c);
        @(negedge clk); chan_wr = 1; chan_wdata = c;
        @(negedge clk); chan_wr = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start_wr = 1;
        @(negedge clk); start_wr = 0;
    endtask

    task automatic pulse_done();
        @(negedge clk); conv_done = 1;
        @(negedge clk); conv_done = 0;
    endtask

    task automatic ack(input logic [1:0] m);
        @(negedge clk); irq_ack_wr = 1; irq_ack_data = m;
        @(negedge clk); irq_ack_wr = 0; irq_ack_data = '0;
    endtask

    // after a restarting write: measure busy window length
    task automatic measure_settle(input string req);
        int len = 0;
        while (settle_busy && len < 4 * N) begin
            @(negedge clk); len++;
        end
        chk(req, len, N);
    endtask

    task automatic wait_idle();
        while (settle_busy) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 reset rdata", ctrl_rdata, 0);
        chk("R1 reset busy", {settle_busy, conv_busy}, 0);
        chk("R10 reset irq", {irq_pending, irq}, 0);
    endtask

    task automatic t_fields();
        // bit11 set also aborts; reserved bits set
        wr_ctrl(32'hFFFF_F81F | (32'h1 << 8));
        chk("R1 reserved masked", ctrl_rdata, 32'h0000_0100);
        chk("R2 rst reads 0", ctrl_rdata[11], 0);
        chk("R2 no settle after abort", settle_busy, 0);
        wr_ctrl(32'h0);
    endtask

    task automatic t_gain_mode();
        for (int g = 0; g < 4; g++) begin
            wr_ctrl(32'(g) << 6);
            chk("R3 gain_sel", gain_sel, g);
            wait_idle();
        end
        wr_ctrl(32'h20);
        chk("R4 diff_mode on", diff_mode, 1);
        chk("R5 mode change restarts", settle_busy, 1);
        measure_settle("R5 settle length mode");
        wr_ctrl(32'h00);
        chk("R4 diff_mode off", diff_mode, 0);
        wait_idle();
    endtask

    task automatic t_restart();
        wr_ctrl(32'h00);
        chk("R5 no-change write no settle", settle_busy, 0);
        wr_ctrl(32'h600); // irq enables only
        chk("R5 enable-only write no settle", settle_busy, 0);
        wr_chan(5'd7);
        chk("R5 channel change restarts", settle_busy, 1);
        chk("R5 chan_sel", chan_sel, 7);
        measure_settle("R5 settle length chan");
        wr_chan(5'd7);
        chk("R5 same channel no settle", settle_busy, 0);
        wr_ctrl(32'h0);
        ack(2'b11);
    endtask

    task automatic t_auto();
        int s0;
        s0 = starts;
        wr_ctrl(32'h140); // auto, gain 01
        for (int i = 0; i < N - 1; i++) @(negedge clk);
        chk("R6 still settling", {settle_busy, conv_busy}, 2'b10);
        @(negedge clk);
        chk("R6 auto conv busy", {settle_busy, conv_busy}, 2'b01);
        chk("R6 one start", starts - s0, 1);
        pulse_done();
        chk("R6 busy clears on done", conv_busy, 0);
        chk("R9 no irq when disabled", irq_pending, 0);
    endtask

    task automatic t_manual();
        int s0;
        s0 = starts;
        wr_ctrl(32'h080); // manual, gain 10
        pulse_start();
        chk("R7 start ignored while settling", starts - s0, 0);
        wait_idle();
        @(negedge clk);
        chk("R7 no auto start in manual", {conv_busy, 32'(starts - s0)}, 0);
        pulse_start();
        chk("R7 manual start accepted", {conv_busy, 32'(starts - s0)}, {1'b1, 32'd1});
        pulse_start();
        chk("R7 start ignored while converting", starts - s0, 1);
        pulse_done();
        chk("R7 conv idle", conv_busy, 0);
    endtask

    task automatic t_irq();
        wr_ctrl(32'h6C0); // both enables, manual, gain 11
        wait_idle();
        chk("R8 settle pending", irq_pending, 2'b01);
        chk("R10 irq high", irq, 1);
        pulse_start();
        pulse_done();
        chk("R9 conv pending", irq_pending, 2'b11);
        ack(2'b01);
        chk("R10 ack bit0 only", irq_pending, 2'b10);
        chk("R10 irq still high", irq, 1);
        ack(2'b10);
        chk("R10 all cleared", {irq_pending, irq}, 0);
        wr_ctrl(32'h400); // settle irq disabled, gain change
        wait_idle();
        chk("R8 disabled no pending", irq_pending, 0);
    endtask

    task automatic t_abort();
        int a0;
        wr_ctrl(32'h6C0);
        wait_idle();
        pulse_start();
        wr_ctrl(32'h600); // gain change -> settling, conv busy
        chk("R2 pre busy", {settle_busy, conv_busy, irq_pending}, 4'b1101);
        a0 = aborts;
        wr_ctrl(32'h800 | 32'h6C0);
        chk("R2 abort pulse", aborts - a0, 1);
        chk("R2 all cleared", {settle_busy, conv_busy, irq_pending, irq}, 0);
        chk("R2 fields kept, bit11 zero", ctrl_rdata, 32'h6C0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_fields();
        t_gain_mode();
        t_restart();
        t_auto();
        t_manual();
        t_irq();
        t_abort();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule